// File: doc/BRIEF.md
# Programmable Display Timing Signal Generator

This block sits after an upstream frame generator in the pixel clock domain. Each cycle it receives the current raster position and the upstream horizontal sync, vertical sync and data-enable. It drives four control outputs: horizontal sync, vertical sync, data enable and a chunk-synchronisation pulse. The pulse lets a downstream prefetch engine stay aligned to the frame.

Each output is built in two stages. Set/reset pattern generators hold a level that turns on at a masked position compare and off at a second masked compare. A small mixer per output then picks up to three generator levels and maps them through a programmable truth table. A control bit selects between bypass mode and operation mode. In bypass mode the upstream signals pass through. In operation mode the generated signals are driven. A change of mode takes effect only at the first pixel of a frame, so a frame is never split between the two modes. A single-cycle write port loads all configuration.

Top module: `dsp_timing_gen`

## Requirements
- R1: While reset is asserted all four outputs are 0. Reset leaves the block in bypass mode with every other configuration register at 0.
- R2: In bypass mode, hsync_o, vsync_o and de_o equal up_hsync_i, up_vsync_i and up_de_i from the previous cycle, and chunk_o is 0.
- R3: A write to the bypass bit changes the mode only when the raster reaches X = 0, Y = 0. Output for that position and every later one uses the new mode. Positions before it use the old mode.
- R4: A position word holds X in bits 30:16 and Y in bits 14:0; bits 31 and 15 are ignored. A compare matches when every unmasked field bit equals the raster bit. A mask bit of 1 removes that bit from the compare.
- R5: A pattern generator's level becomes 1 at a position whose on-compare matches, and 0 at a position whose off-compare matches. The off-compare wins when both match. Otherwise the level holds.
- R6: A mixer's select register has three 3-bit fields; field i sits in bits 3i+2:3i. Code k in 2..6 selects pattern generator k-2. Codes 0, 1 and 7 select a constant 0.
- R7: A mixer's output is bit {in2,in1,in0} of its 8-bit function table, where ini is the value selected by field i.
- R8: Mixer 0 drives hsync_o, mixer 1 vsync_o, mixer 2 de_o and mixer 3 chunk_o. Every output is registered and shows the value for the raster position presented one cycle earlier.
- R9: Register word addresses: 0 is control, with the bypass flag in bit 3. Generator n uses 4+4n (on position), 5+4n (on mask), 6+4n (off position) and 7+4n (off mask). Mixer m uses 24+2m (select) and 25+2m (table).
- R10: With the standard program the outputs behave as follows. hsync_o is low for X in [hs_start, hs_end). vsync_o is low from (hs_start, vs_start-1) up to (hs_start, vs_end-1). de_o is high for X < hdisplay and Y < vdisplay. chunk_o is high on line vdisplay+1 for X < 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| x_i | input | COORD_W | Raster column |
| y_i | input | COORD_W | Raster line |
| up_hsync_i | input | 1 | Upstream horizontal sync |
| up_vsync_i | input | 1 | Upstream vertical sync |
| up_de_i | input | 1 | Upstream data enable |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 5 | Configuration word address |
| wr_data_i | input | 32 | Configuration write data |
| hsync_o | output | 1 | Horizontal sync out |
| vsync_o | output | 1 | Vertical sync out |
| de_o | output | 1 | Data enable out |
| chunk_o | output | 1 | Chunk-synchronisation pulse |

## Verification
Every output has one register between the raster inputs and the pin. The result for a position driven at one falling edge is therefore due after the next rising edge. The bench checks it at the following falling edge, just before it drives the next position. Bypass outputs follow the same one-cycle rule, using the upstream values that were driven together with the position. A write of the bypass bit updates the pending flag at the next rising edge. The bench's mode model changes only at the next position (0,0), and it compares the full frame on both sides of that point.

// File: rtl/tcg_pkg.sv
`timescale 1ns/1ps
package tcg_pkg;
   localparam int WORD_W     = 32;
   localparam int POS_W      = 15;
   localparam int ADDR_W     = 5;
   localparam int CTRL_ADDR  = 0;
   localparam int PG_BASE    = 4;
   localparam int MIX_BASE   = 24;
   localparam int BYPASS_BIT = 3;
   localparam int NUM_OUT    = 4;
   // X in 30:16, Y in 14:0; bits 31 and 15 never take part in a compare
   localparam logic [WORD_W-1:0] FIELD_MASK = 32'h7FFF_7FFF;

   function automatic logic [WORD_W-1:0] pos_word(input logic [POS_W-1:0] xv,
                                                  input logic [POS_W-1:0] yv);
      return {1'b0, xv, 1'b0, yv};
   endfunction
endpackage

// File: rtl/tcg_regs.sv
`timescale 1ns/1ps
module tcg_regs
   import tcg_pkg::*;
#(
   parameter int NUM_PG   = 5,
   parameter int NUM_MIX  = 4,
   parameter int SEL_BITS = 9,
   parameter int TBL_BITS = 8
)(
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en_i,
   input  logic [ADDR_W-1:0]                   wr_addr_i,
   input  logic [WORD_W-1:0]                   wr_data_i,
   output logic                                pend_bypass_o,
   output logic [NUM_PG-1:0][WORD_W-1:0]       on_pos_o,
   output logic [NUM_PG-1:0][WORD_W-1:0]       on_mask_o,
   output logic [NUM_PG-1:0][WORD_W-1:0]       off_pos_o,
   output logic [NUM_PG-1:0][WORD_W-1:0]       off_mask_o,
   output logic [NUM_MIX-1:0][SEL_BITS-1:0]    mix_sel_o,
   output logic [NUM_MIX-1:0][TBL_BITS-1:0]    mix_tbl_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_bypass_o <= 1'b1;
      else if (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR))
         pend_bypass_o <= wr_data_i[BYPASS_BIT];
   end

   for (genvar g = 0; g < NUM_PG; g++) begin : g_pg_regs
      localparam int BASE = PG_BASE + 4*g;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            on_pos_o[g]   <= '0;
            on_mask_o[g]  <= '0;
            off_pos_o[g]  <= '0;
            off_mask_o[g] <= '0;
         end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(BASE))     on_pos_o[g]   <= wr_data_i;
            if (wr_addr_i == ADDR_W'(BASE + 1)) on_mask_o[g]  <= wr_data_i;
            if (wr_addr_i == ADDR_W'(BASE + 2)) off_pos_o[g]  <= wr_data_i;
            if (wr_addr_i == ADDR_W'(BASE + 3)) off_mask_o[g] <= wr_data_i;
         end
      end
   end

   for (genvar m = 0; m < NUM_MIX; m++) begin : g_mix_regs
      localparam int BASE = MIX_BASE + 2*m;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mix_sel_o[m] <= '0;
            mix_tbl_o[m] <= '0;
         end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(BASE))     mix_sel_o[m] <= wr_data_i[SEL_BITS-1:0];
            if (wr_addr_i == ADDR_W'(BASE + 1)) mix_tbl_o[m] <= wr_data_i[TBL_BITS-1:0];
         end
      end
   end
endmodule

// File: rtl/tcg_pattern_gen.sv
`timescale 1ns/1ps
module tcg_pattern_gen
   import tcg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] cur_word_i,
   input  logic [WORD_W-1:0] on_pos_i,
   input  logic [WORD_W-1:0] on_mask_i,
   input  logic [WORD_W-1:0] off_pos_i,
   input  logic [WORD_W-1:0] off_mask_i,
   output logic              level_o
);
   logic state_q;
   logic on_hit, off_hit;

   assign on_hit  = (((cur_word_i ^ on_pos_i)  & ~on_mask_i)  & FIELD_MASK) == '0;
   assign off_hit = (((cur_word_i ^ off_pos_i) & ~off_mask_i) & FIELD_MASK) == '0;

   // level for the current position: clear dominates, then set, else hold
   always_comb begin
      if (off_hit)     level_o = 1'b0;
      else if (on_hit) level_o = 1'b1;
      else             level_o = state_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= 1'b0;
      else        state_q <= level_o;
   end
endmodule

// File: rtl/tcg_mixer.sv
`timescale 1ns/1ps
module tcg_mixer #(
   parameter int NUM_PG = 5,
   parameter int SEL_W  = 3,
   parameter int MIX_IN = 3,
   localparam int SEL_BITS = SEL_W * MIX_IN,
   localparam int TBL_BITS = 1 << MIX_IN
)(
   input  logic [NUM_PG-1:0]   pg_lvl_i,
   input  logic [SEL_BITS-1:0] sel_i,
   input  logic [TBL_BITS-1:0] tbl_i,
   output logic                y_o
);
   logic [MIX_IN-1:0] idx;

   always_comb begin
      for (int i = 0; i < MIX_IN; i++) begin
         idx[i] = 1'b0;
         for (int p = 0; p < NUM_PG; p++)
            if (sel_i[i*SEL_W +: SEL_W] == SEL_W'(p + 2))
               idx[i] = pg_lvl_i[p];
      end
   end

   assign y_o = tbl_i[idx];
endmodule

// File: rtl/dsp_timing_gen.sv
`timescale 1ns/1ps
module dsp_timing_gen
   import tcg_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int NUM_PG  = 5,
   parameter int SEL_W   = 3,
   parameter int MIX_IN  = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COORD_W-1:0] x_i,
   input  logic [COORD_W-1:0] y_i,
   input  logic               up_hsync_i,
   input  logic               up_vsync_i,
   input  logic               up_de_i,
   input  logic               wr_en_i,
   input  logic [4:0]         wr_addr_i,
   input  logic [31:0]        wr_data_i,
   output logic               hsync_o,
   output logic               vsync_o,
   output logic               de_o,
   output logic               chunk_o
);
   localparam int SEL_BITS = SEL_W * MIX_IN;
   localparam int TBL_BITS = 1 << MIX_IN;

   if (COORD_W < 1 || COORD_W > POS_W) begin : g_bad_coord
      $error("COORD_W must lie in 1..15");
   end
   if (NUM_PG + 2 > (1 << SEL_W)) begin : g_bad_sel
      $error("selector codes cannot reach every pattern generator");
   end
   if (PG_BASE + 4*NUM_PG > MIX_BASE) begin : g_bad_map
      $error("pattern generator registers overlap mixer registers");
   end
   if (SEL_BITS > WORD_W || TBL_BITS > WORD_W) begin : g_bad_mix
      $error("mixer registers wider than a data word");
   end

   logic                              pend_bypass;
   logic [NUM_PG-1:0][WORD_W-1:0]     on_pos, on_mask, off_pos, off_mask;
   logic [NUM_OUT-1:0][SEL_BITS-1:0]  mix_sel;
   logic [NUM_OUT-1:0][TBL_BITS-1:0]  mix_tbl;
   logic [NUM_PG-1:0]                 pg_lvl;
   logic [NUM_OUT-1:0]                gen_lvl;
   logic [WORD_W-1:0]                 cur_word;
   logic                              at_origin, eff_bypass, mode_q;
   logic [NUM_OUT-1:0]                out_q, out_d;

   tcg_regs #(
      .NUM_PG(NUM_PG), .NUM_MIX(NUM_OUT), .SEL_BITS(SEL_BITS), .TBL_BITS(TBL_BITS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .pend_bypass_o(pend_bypass),
      .on_pos_o(on_pos), .on_mask_o(on_mask),
      .off_pos_o(off_pos), .off_mask_o(off_mask),
      .mix_sel_o(mix_sel), .mix_tbl_o(mix_tbl)
   );

   assign cur_word = pos_word(POS_W'(x_i), POS_W'(y_i));

   for (genvar g = 0; g < NUM_PG; g++) begin : g_pg
      tcg_pattern_gen u_pg (
         .clk(clk), .rst_n(rst_n), .cur_word_i(cur_word),
         .on_pos_i(on_pos[g]), .on_mask_i(on_mask[g]),
         .off_pos_i(off_pos[g]), .off_mask_i(off_mask[g]),
         .level_o(pg_lvl[g])
      );
   end

   for (genvar m = 0; m < NUM_OUT; m++) begin : g_mix
      tcg_mixer #(.NUM_PG(NUM_PG), .SEL_W(SEL_W), .MIX_IN(MIX_IN)) u_mix (
         .pg_lvl_i(pg_lvl), .sel_i(mix_sel[m]), .tbl_i(mix_tbl[m]),
         .y_o(gen_lvl[m])
      );
   end

   // mode switches only at the first pixel of a frame
   assign at_origin  = (x_i == '0) && (y_i == '0);
   assign eff_bypass = at_origin ? pend_bypass : mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b1;
      else        mode_q <= eff_bypass;
   end

   assign out_d = eff_bypass ? {1'b0, up_de_i, up_vsync_i, up_hsync_i} : gen_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= out_d;
   end

   assign hsync_o = out_q[0];
   assign vsync_o = out_q[1];
   assign de_o    = out_q[2];
   assign chunk_o = out_q[3];
endmodule

// File: rtl/tcg_chk.sv
`timescale 1ns/1ps
module tcg_chk #(
   parameter int COORD_W = 12
)(
   input logic               clk,
   input logic               rst_n,
   input logic [COORD_W-1:0] x_i,
   input logic [COORD_W-1:0] y_i,
   input logic               up_hsync_i,
   input logic               up_vsync_i,
   input logic               up_de_i,
   input logic               wr_en_i,
   input logic [4:0]         wr_addr_i,
   input logic               wr_bypass_bit,
   input logic               hsync_o,
   input logic               vsync_o,
   input logic               de_o,
   input logic               chunk_o,
   input logic               eff_bypass,
   input logic               mode_q,
   input logic               pend_bypass
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_bypass_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(eff_bypass) |->
         (hsync_o == $past(up_hsync_i)) && (vsync_o == $past(up_vsync_i)) &&
         (de_o == $past(up_de_i)) && !chunk_o);

   assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(x_i == '0 && y_i == '0) |-> $stable(mode_q));

   assert_mode_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(x_i == '0 && y_i == '0) |-> mode_q == $past(pend_bypass));

   assert_ctrl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(wr_en_i && wr_addr_i == 5'd0) |-> pend_bypass == $past(wr_bypass_bit));
endmodule

bind dsp_timing_gen tcg_chk #(.COORD_W(COORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .x_i(x_i), .y_i(y_i),
   .up_hsync_i(up_hsync_i), .up_vsync_i(up_vsync_i), .up_de_i(up_de_i),
   .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_bypass_bit(wr_data_i[3]),
   .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .chunk_o(chunk_o),
   .eff_bypass(eff_bypass), .mode_q(mode_q), .pend_bypass(pend_bypass)
);

// File: tb/dsp_timing_gen_tb_top.sv
`timescale 1ns/1ps
module dsp_timing_gen_tb_top;
   localparam int HT = 40, VT = 12;
   localparam int HD = 24, HS = 28, HE = 32;
   localparam int VD = 8, VS = 9, VE = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] x = 12'd39, y = 12'd11;
   logic        uph = 1'b0, upv = 1'b0, upd = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hs_o, vs_o, de_o, ck_o;

   int checks = 0, fails = 0;
   logic pend_m = 1'b1, mode_m = 1'b1;
   bit   done = 0;

   always #5 clk = ~clk;

   dsp_timing_gen dut_i (
      .clk(clk), .rst_n(rst_n), .x_i(x), .y_i(y),
      .up_hsync_i(uph), .up_vsync_i(upv), .up_de_i(upd),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .hsync_o(hs_o), .vsync_o(vs_o), .de_o(de_o), .chunk_o(ck_o)
   );

   function automatic logic [31:0] pw(input int xv, input int yv);
      return (32'(xv) << 16) | 32'(yv);
   endfunction

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic reg_wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(addr); wr_data = data;
      if (addr == 0) pend_m = data[3];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pg_cfg(input int n, input logic [31:0] onp, input logic [31:0] onm,
                         input logic [31:0] offp, input logic [31:0] offm);
      reg_wr(4 + 4*n, onp); reg_wr(5 + 4*n, onm);
      reg_wr(6 + 4*n, offp); reg_wr(7 + 4*n, offm);
   endtask

   task automatic mix_cfg(input int m, input logic [31:0] sel, input logic [31:0] tbl);
      reg_wr(24 + 2*m, sel); reg_wr(25 + 2*m, tbl);
   endtask

   function automatic logic exp_chunk(input int cfg, input int xv, input int yv);
      logic a, h;
      a = (xv >= 4) && (xv < 8);
      h = (xv >= HS) && (xv < HE);
      case (cfg)
         0: return (yv == VD + 1) && (xv < 32);
         1: return a;
         2: return 1'b0;
         3: return a ^ h;
         default: return 1'b1;
      endcase
   endfunction

   task automatic check_pos(input string req, input int cfg, input int xv, input int yv,
                            input logic md, input logic h, input logic v, input logic d);
      int p;
      p = yv*HT + xv;
      if (md) begin
         chk(req, "bypass hsync", hs_o, h);
         chk(req, "bypass vsync", vs_o, v);
         chk(req, "bypass de", de_o, d);
         chk(req, "bypass chunk", ck_o, 1'b0);
      end else begin
         chk(req, "hsync", hs_o, !((xv >= HS) && (xv < HE)));
         chk(req, "vsync", vs_o, !((p >= (VS-1)*HT + HS) && (p < (VE-1)*HT + HS)));
         chk(req, "de", de_o, (xv < HD) && (yv < VD));
         chk(req, "chunk", ck_o, exp_chunk(cfg, xv, yv));
      end
   endtask

   // one full frame; optional bypass write at (0, wr_y)
   task automatic run_frame(input string req, input int cfg, input int wr_y, input logic wr_val);
      int px = 0, py = 0;
      logic pm = 1'b1, ph = 1'b0, pv = 1'b0, pd = 1'b0;
      bit have = 0;
      for (int yy = 0; yy < VT; yy++) begin
         for (int xx = 0; xx < HT; xx++) begin
            @(negedge clk);
            if (have) check_pos(req, cfg, px, py, pm, ph, pv, pd);
            x = 12'(xx); y = 12'(yy);
            uph = x[0]; upv = y[0] ^ x[2]; upd = x[1] & x[3];
            if (xx == 0 && yy == 0) mode_m = pend_m;
            if (xx == 0 && yy == wr_y) begin
               wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'(wr_val) << 3;
               pend_m = wr_val;
            end else begin
               wr_en = 1'b0;
            end
            px = xx; py = yy; pm = mode_m; ph = uph; pv = upv; pd = upd;
            have = 1;
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      check_pos(req, cfg, px, py, pm, ph, pv, pd);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet while reset is held
      chk("R1", "hsync in reset", hs_o, 1'b0);
      chk("R1", "vsync in reset", vs_o, 1'b0);
      chk("R1", "de in reset", de_o, 1'b0);
      chk("R1", "chunk in reset", ck_o, 1'b0);
      rst_n = 1'b1;
      // R1, R2: reset leaves bypass mode
      run_frame("R1,R2", 0, -1, 1'b0);
      // standard program, R9 register map
      pg_cfg(0, pw(HS, 0), 32'h0000_FFFF, pw(HE, 0), 32'h0000_FFFF);
      pg_cfg(1, pw(HS, VS-1), 32'h0, pw(HS, VE-1), 32'h0);
      pg_cfg(2, 32'h0, 32'h0000_FFFF, pw(HD, 0), 32'h0000_FFFF);
      pg_cfg(3, 32'h0, 32'h7FFF_0000, pw(0, VD), 32'h7FFF_0000);
      pg_cfg(4, pw(0, VD+1), 32'h0, pw(32, VD+1), 32'h0);
      mix_cfg(0, 32'h2, 32'h1);
      mix_cfg(1, 32'h3, 32'h1);
      mix_cfg(2, 32'h2c, 32'h8);
      mix_cfg(3, 32'h6, 32'h2);
      // R3: operation requested mid-frame, frame stays bypass
      run_frame("R3", 0, 4, 1'b0);
      // R9, R10: operation frame; bypass requested mid-frame stays deferred (R3)
      run_frame("R3,R9,R10", 0, 5, 1'b1);
      run_frame("R3", 0, -1, 1'b0);
      // R3: write between frames takes effect at the next origin
      reg_wr(0, 32'h0);
      run_frame("R8,R10", 0, -1, 1'b0);
      // R4: mask drops X bit 0 so the on-compare at X=5 also hits X=4
      pg_cfg(4, pw(5, 0), 32'h0001_FFFF, pw(8, 0), 32'h0000_FFFF);
      run_frame("R4", 1, -1, 1'b0);
      // R5: on and off at the same position, clear wins
      pg_cfg(4, pw(10, 0), 32'h0000_FFFF, pw(10, 0), 32'h0000_FFFF);
      run_frame("R5", 2, -1, 1'b0);
      // R7, R6: field 1 code 2 (generator 0), field 0 code 6 (generator 4), XOR table
      pg_cfg(4, pw(5, 0), 32'h0001_FFFF, pw(8, 0), 32'h0000_FFFF);
      mix_cfg(3, 32'h16, 32'h6);
      run_frame("R7", 3, -1, 1'b0);
      // R6: code 7 is a constant 0, table 0x1 inverts it
      mix_cfg(3, 32'h7, 32'h1);
      run_frame("R6", 4, -1, 1'b0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule